// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregation Unit

This block sits beside a CAN controller core and turns its many event signals into four interrupt request lines: one for transmission, one for each of the two receive FIFOs, and one for error and status changes. The core sends it one-cycle pulses when a transmit mailbox empties, when a FIFO fills or overruns, on wakeup and on sleep acknowledge. It also sends live levels for the error-warning, error-passive and bus-off states, the 3-bit last-error code and the 2-bit message-pending count of each FIFO.

Event pulses are caught in sticky flags. Software clears a flag by writing 1 to its bit. An enable register masks every source. The error line has two stages: the individually enabled error sources first set a sticky summary flag, and that summary flag then passes through its own enable. All four request lines are registered.

A small register bus gives access to the enable mask (read/write), the flags (read, write-1-to-clear) and the live pending counts (read only). Reads are combinational from the address. Writes take effect at the clock edge.

Top module: `can_irq_aggr`

## Requirements
- R1: `irq_tx` is high when the transmit enable (enable bit 0) is set and any of the three mailbox-empty flags (flag bits 2..0) is set.
- R2: Each FIFO line `irq_rx[i]` is the OR of three terms. Each term uses enable bits 1+3i (pending), 2+3i (full) and 3+3i (overrun):
  - the pending count of FIFO i is not 00 AND the pending enable;
  - the full flag (flag bit 3+2i) AND the full enable;
  - the overrun flag (flag bit 4+2i) AND the overrun enable.
- R3: The pending term follows the live `rx_pend` count and is not stored. A FIFO line held up only by that term drops one clock after the count returns to 00.
- R4: The last-error code counts as an error source only for codes 1 to 6. Codes 0 and 7 never set the summary error flag, even when the code enable (enable bit 10) is set.
- R5: The summary error flag (flag bit 7) is set in any cycle where one of these enabled sources is active:
  - warning AND enable bit 7;
  - passive AND enable bit 8;
  - bus-off AND enable bit 9;
  - code condition AND enable bit 10.
- R6: `irq_sce` is the OR of three terms:
  - summary flag AND enable bit 11;
  - wakeup flag (flag bit 8) AND enable bit 12;
  - sleep-acknowledge flag (flag bit 9) AND enable bit 13.
- R7: A sticky flag is set by a one-cycle event and stays set. Writing 1 to its bit at address 1 clears it. When a set and a clear meet in the same cycle, the flag ends up set.
- R8: Each interrupt output changes one clock after the flag/enable/count combination that drives it. Clearing an enable drops the output on the next clock and leaves the stored flag unchanged.
- R9: After reset, all flags, all enables and all four interrupt outputs are 0.
- R10: Address 0 reads back the 14-bit enable mask and writes it. Address 1 reads the 10 flags, and a write there only clears. Address 2 reads the pending counts, FIFO 0 in bits 1..0 and FIFO 1 in bits 3..2, and ignores writes. Address 3 reads 0. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_ev | input | 3 | Mailbox-empty pulses, one per mailbox |
| rx_pend | input | 4 | Live pending counts, 2 bits per FIFO |
| rx_full_ev | input | 2 | FIFO-full pulses |
| rx_ovr_ev | input | 2 | FIFO-overrun pulses |
| err_warn | input | 1 | Error-warning level |
| err_passive | input | 1 | Error-passive level |
| err_busoff | input | 1 | Bus-off level |
| err_code | input | 3 | Last-error code |
| wake_ev | input | 1 | Wakeup pulse |
| sleep_ack_ev | input | 1 | Sleep-acknowledge pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 2 | Receive FIFO interrupts |
| irq_sce | output | 1 | Error/status-change interrupt |

## Verification
Random event pulses, error levels, codes and register writes run against a cycle model in the bench. This shows whether every source reaches its own line through its own enable bit and not through a neighbour's. Directed sequences cover the following:
- Codes 0 and 7 with all error enables on. These tell a correct 1..6 range from a plain nonzero test.
- A wakeup pulse in the same cycle as its clear. This separates set-wins from clear-wins.
- A pending count that rises and falls, against a full pulse. This separates the level term from the sticky terms.
- Dropping an enable while its flag stays. This shows that masking and clearing are independent.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_MBOX = 3;
  localparam int NUM_FIFO = 2;
  localparam int REG_DW   = 16;
  localparam int CODE_W   = 3;
  localparam int PEND_W   = 2;

  // enable register layout
  localparam int EN_TX        = 0;
  localparam int EN_FIFO_BASE = 1;
  localparam int EN_WARN      = EN_FIFO_BASE + 3 * NUM_FIFO;
  localparam int EN_PASS      = EN_WARN + 1;
  localparam int EN_BOFF      = EN_WARN + 2;
  localparam int EN_CODE      = EN_WARN + 3;
  localparam int EN_ERR       = EN_WARN + 4;
  localparam int EN_WAKE      = EN_WARN + 5;
  localparam int EN_SLEEP     = EN_WARN + 6;
  localparam int EN_W         = EN_WARN + 7;

  // sticky flag layout
  localparam int FL_FIFO_BASE = NUM_MBOX;
  localparam int FL_ERR       = NUM_MBOX + 2 * NUM_FIFO;
  localparam int FL_WAKE      = FL_ERR + 1;
  localparam int FL_SLAK      = FL_ERR + 2;
  localparam int FL_W         = FL_ERR + 3;

  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_PEND = 2'd2;

  function automatic logic code_is_err(input logic [CODE_W-1:0] c);
    return (c != '0) && (c != '1);
  endfunction

  function automatic logic pend_nz(input logic [PEND_W-1:0] p);
    return |p;
  endfunction
endpackage

// File: rtl/can_irq_sticky.sv
module can_irq_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  // set dominates a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/can_irq_fifo_term.sv
module can_irq_fifo_term
  import can_irq_pkg::*;
(
  input  logic [PEND_W-1:0] pend_i,
  input  logic              full_i,
  input  logic              ovr_i,
  input  logic [2:0]        en_i,   // [0] pending, [1] full, [2] overrun
  output logic              req_o
);
  always_comb begin
    req_o = (pend_nz(pend_i) && en_i[0]) ||
            (full_i && en_i[1]) ||
            (ovr_i  && en_i[2]);
  end
endmodule

// File: rtl/can_irq_err_src.sv
module can_irq_err_src
  import can_irq_pkg::*;
(
  input  logic              warn_i,
  input  logic              pass_i,
  input  logic              boff_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [3:0]        en_i,   // [0] warn, [1] passive, [2] bus-off, [3] code
  output logic              hit_o
);
  always_comb begin
    hit_o = (warn_i && en_i[0]) ||
            (pass_i && en_i[1]) ||
            (boff_i && en_i[2]) ||
            (code_is_err(code_i) && en_i[3]);
  end
endmodule

// File: rtl/can_irq_aggr.sv
module can_irq_aggr
  import can_irq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MBOX-1:0]        tx_done_ev,
  input  logic [PEND_W*NUM_FIFO-1:0] rx_pend,
  input  logic [NUM_FIFO-1:0]        rx_full_ev,
  input  logic [NUM_FIFO-1:0]        rx_ovr_ev,
  input  logic                       err_warn,
  input  logic                       err_passive,
  input  logic                       err_busoff,
  input  logic [CODE_W-1:0]          err_code,
  input  logic                       wake_ev,
  input  logic                       sleep_ack_ev,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [REG_DW-1:0]          reg_wdata,
  output logic [REG_DW-1:0]          reg_rdata,
  output logic                       irq_tx,
  output logic [NUM_FIFO-1:0]        irq_rx,
  output logic                       irq_sce
);
  logic [EN_W-1:0]     en_q;
  logic [FL_W-1:0]     flag_q;
  logic [FL_W-1:0]     flag_set;
  logic [FL_W-1:0]     flag_clr;
  logic                err_hit;
  logic [NUM_FIFO-1:0] fifo_req;
  logic                en_wr;
  logic                flag_wr;
  logic                unused_wdata;

  assign en_wr        = reg_wr && (reg_addr == ADDR_EN);
  assign flag_wr      = reg_wr && (reg_addr == ADDR_FLAG);
  assign unused_wdata = ^reg_wdata[REG_DW-1:EN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata[EN_W-1:0];
  end

  can_irq_err_src u_err (
    .warn_i (err_warn),
    .pass_i (err_passive),
    .boff_i (err_busoff),
    .code_i (err_code),
    .en_i   (en_q[EN_CODE:EN_WARN]),
    .hit_o  (err_hit)
  );

  always_comb begin
    flag_set = '0;
    flag_set[NUM_MBOX-1:0] = tx_done_ev;
    for (int i = 0; i < NUM_FIFO; i++) begin
      flag_set[FL_FIFO_BASE + 2*i]     = rx_full_ev[i];
      flag_set[FL_FIFO_BASE + 2*i + 1] = rx_ovr_ev[i];
    end
    flag_set[FL_ERR]  = err_hit;
    flag_set[FL_WAKE] = wake_ev;
    flag_set[FL_SLAK] = sleep_ack_ev;
    flag_clr = flag_wr ? reg_wdata[FL_W-1:0] : '0;
  end

  can_irq_sticky #(.W(FL_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    can_irq_fifo_term u_term (
      .pend_i (rx_pend[PEND_W*g +: PEND_W]),
      .full_i (flag_q[FL_FIFO_BASE + 2*g]),
      .ovr_i  (flag_q[FL_FIFO_BASE + 2*g + 1]),
      .en_i   (en_q[EN_FIFO_BASE + 3*g +: 3]),
      .req_o  (fifo_req[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx  <= 1'b0;
      irq_rx  <= '0;
      irq_sce <= 1'b0;
    end else begin
      irq_tx  <= (|flag_q[NUM_MBOX-1:0]) && en_q[EN_TX];
      irq_rx  <= fifo_req;
      irq_sce <= (flag_q[FL_ERR]  && en_q[EN_ERR])  ||
                 (flag_q[FL_WAKE] && en_q[EN_WAKE]) ||
                 (flag_q[FL_SLAK] && en_q[EN_SLEEP]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_EN:   reg_rdata[EN_W-1:0] = en_q;
      ADDR_FLAG: reg_rdata[FL_W-1:0] = flag_q;
      ADDR_PEND: reg_rdata[PEND_W*NUM_FIFO-1:0] = rx_pend;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_irq_aggr_chk.sv
module can_irq_aggr_chk
  import can_irq_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [EN_W-1:0]            en_q,
  input logic [FL_W-1:0]            flag_q,
  input logic [PEND_W*NUM_FIFO-1:0] rx_pend,
  input logic                       err_warn,
  input logic                       err_passive,
  input logic                       err_busoff,
  input logic [CODE_W-1:0]          err_code,
  input logic                       wake_ev,
  input logic                       irq_tx,
  input logic [NUM_FIFO-1:0]        irq_rx,
  input logic                       irq_sce
);
  p_tx_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[EN_TX] |=> !irq_tx);

  p_tx_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[EN_TX] && (|flag_q[NUM_MBOX-1:0])) |=> irq_tx);

  p_pend_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_pend[PEND_W-1:0] != '0) && en_q[EN_FIFO_BASE]) |=> irq_rx[0]);

  p_code_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_code == 3'd0 || err_code == 3'd7) && !err_warn && !err_passive &&
     !err_busoff && !flag_q[FL_ERR]) |=> !flag_q[FL_ERR]);

  p_sce_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[EN_ERR] && !en_q[EN_WAKE] && !en_q[EN_SLEEP]) |=> !irq_sce);

  p_wake_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev |=> flag_q[FL_WAKE]);
endmodule

bind can_irq_aggr can_irq_aggr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_q        (en_q),
  .flag_q      (flag_q),
  .rx_pend     (rx_pend),
  .err_warn    (err_warn),
  .err_passive (err_passive),
  .err_busoff  (err_busoff),
  .err_code    (err_code),
  .wake_ev     (wake_ev),
  .irq_tx      (irq_tx),
  .irq_rx      (irq_rx),
  .irq_sce     (irq_sce)
);

// File: tb/tb_can_irq_aggr.sv
`timescale 1ns/1ps
module tb_can_irq_aggr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  tx_done_ev;
  logic [3:0]  rx_pend;
  logic [1:0]  rx_full_ev, rx_ovr_ev;
  logic        err_warn, err_passive, err_busoff;
  logic [2:0]  err_code;
  logic        wake_ev, sleep_ack_ev;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_tx, irq_sce;
  logic [1:0]  irq_rx;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  can_irq_aggr dut (.*);

  // bench model state
  logic [13:0] m_en;
  logic [9:0]  m_fl;
  logic        m_tx, m_sce;
  logic [1:0]  m_rx;

  function automatic logic b_code_bad(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd6);
  endfunction

  function automatic logic b_fifo(input logic [1:0] p, input logic fu, input logic ov,
                                  input logic [2:0] e);
    logic r;
    r = 1'b0;
    if (p != 2'b00 && e[0]) r = 1'b1;
    if (fu && e[1]) r = 1'b1;
    if (ov && e[2]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] b_read(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_en};
      2'd1:    return {6'b0, m_fl};
      2'd2:    return {12'b0, rx_pend};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_fl = '0; m_tx = 1'b0; m_rx = '0; m_sce = 1'b0;
    end else begin
      logic [9:0] setv, clrv;
      logic hit;
      m_tx  = (m_fl[2:0] != 3'b000) && m_en[0];
      m_rx[0] = b_fifo(rx_pend[1:0], m_fl[3], m_fl[4], m_en[3:1]);
      m_rx[1] = b_fifo(rx_pend[3:2], m_fl[5], m_fl[6], m_en[6:4]);
      m_sce = (m_fl[7] && m_en[11]) || (m_fl[8] && m_en[12]) || (m_fl[9] && m_en[13]);
      hit = (err_warn && m_en[7]) || (err_passive && m_en[8]) ||
            (err_busoff && m_en[9]) || (b_code_bad(err_code) && m_en[10]);
      setv = {sleep_ack_ev, wake_ev, hit, rx_ovr_ev[1], rx_full_ev[1],
              rx_ovr_ev[0], rx_full_ev[0], tx_done_ev};
      clrv = (reg_wr && reg_addr == 2'd1) ? reg_wdata[9:0] : 10'b0;
      m_fl = (m_fl & ~clrv) | setv;
      if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[13:0];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    tx_done_ev = '0; rx_full_ev = '0; rx_ovr_ev = '0;
    wake_ev = 1'b0; sleep_ack_ev = 1'b0; reg_wr = 1'b0;
  endtask

  // advance one clock, then compare outputs with the model (R8 timing)
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R1 irq_tx", {15'b0, irq_tx}, {15'b0, m_tx});
    chk("R2 irq_rx", {14'b0, irq_rx}, {14'b0, m_rx});
    chk("R6 irq_sce", {15'b0, irq_sce}, {15'b0, m_sce});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    idle();
    rx_pend = '0; err_warn = 0; err_passive = 0; err_busoff = 0; err_code = '0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 irq_tx", {15'b0, irq_tx}, 16'h0);
    chk("R9 irq_rx", {14'b0, irq_rx}, 16'h0);
    chk("R9 irq_sce", {15'b0, irq_sce}, 16'h0);
    rd_chk("R9 enables", 2'd0, 16'h0);
    rd_chk("R9 flags", 2'd1, 16'h0);
    rst_n = 1'b1;
    tick();

    // R10 enable readback, writes to pend/addr3 ignored
    wr(2'd0, 16'hFFFF);
    rd_chk("R10 enable rw", 2'd0, 16'h3FFF);
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'h5555);
    rd_chk("R10 enable untouched", 2'd0, 16'h3FFF);
    rd_chk("R10 addr3 zero", 2'd3, 16'h0);

    // R4 codes 0 and 7 never raise the summary flag
    wr(2'd0, 16'h0C00);           // code enable + summary enable
    err_code = 3'd0; tick(); tick();
    err_code = 3'd7; tick(); tick();
    rd_chk("R4 code 0/7 flag", 2'd1, 16'h0);
    chk("R4 irq_sce quiet", {15'b0, irq_sce}, 16'h0);
    err_code = 3'd6; tick();
    err_code = 3'd0;
    rd_chk("R5 code 6 sets summary", 2'd1, 16'h0080);
    tick();
    chk("R6 summary reaches sce", {15'b0, irq_sce}, 16'h1);
    wr(2'd1, 16'h0080);
    rd_chk("R7 summary cleared", 2'd1, 16'h0);

    // R7 set wins over simultaneous clear
    wake_ev = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0100;
    tick();
    idle();
    rd_chk("R7 set beats clear", 2'd1, 16'h0100);
    wr(2'd1, 16'h0100);
    rd_chk("R7 w1c clears", 2'd1, 16'h0);

    // R8 enable drop keeps flag
    wr(2'd0, 16'h0001);
    tx_done_ev = 3'b100; tick(); idle();
    tick();
    chk("R1 tx raised", {15'b0, irq_tx}, 16'h1);
    wr(2'd0, 16'h0000);
    tick();
    chk("R8 tx dropped", {15'b0, irq_tx}, 16'h0);
    rd_chk("R8 flag kept", 2'd1, 16'h0004);
    wr(2'd1, 16'h03FF);

    // R3 pending level term
    wr(2'd0, 16'h0002);
    rx_pend = 4'b0001; tick(); tick(); tick();
    chk("R3 pending held", {14'b0, irq_rx}, 16'h1);
    rd_chk("R10 pend readback", 2'd2, 16'h0001);
    rx_pend = 4'b0000; tick();
    chk("R3 pending released", {14'b0, irq_rx}, 16'h0);
    rx_full_ev = 2'b01; tick(); idle(); tick();
    chk("R2 full w/o full enable", {14'b0, irq_rx}, 16'h0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      tx_done_ev   = (r[3:0] == 4'd0) ? r[6:4] : 3'b0;
      rx_full_ev   = (r[9:7] == 3'd0) ? r[11:10] : 2'b0;
      rx_ovr_ev    = (r[14:12] == 3'd0) ? r[16:15] : 2'b0;
      wake_ev      = (r[20:17] == 4'd0);
      sleep_ack_ev = (r[24:21] == 4'd0);
      r = $urandom;
      if (r[2:0] == 3'd0) rx_pend = r[6:3];
      err_warn    = (r[10:7] == 4'd0) ? ~err_warn : err_warn;
      err_passive = (r[14:11] == 4'd0) ? ~err_passive : err_passive;
      err_busoff  = (r[18:15] == 4'd0) ? ~err_busoff : err_busoff;
      err_code    = r[21:19];
      reg_wr    = (r[24:22] == 3'd0);
      reg_addr  = r[26:25];
      reg_wdata = 16'($urandom);
      #1;
      chk("R10 read", reg_rdata, b_read(reg_addr));
      tick();
    end
    idle();
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule